// File: doc/BRIEF.md
# Zero-Flush Reset Pipeline

This block is an arithmetic pipeline of add and scale stages with a small reset sequencer beside it. The data registers of the stages have no reset. To bring the pipeline to a known state, the sequencer runs a flush window instead. During that window the value fed to the first stage is replaced by zero, and the output is held at zero. The window lasts as many enabled cycles as the pipeline is deep. When it closes, every stage holds data that came from zeros, so nothing stale can reach the output. From outside, the block cannot be told apart from a copy in which every register was cleared.

Data moves in a plain valid-qualified stream. The block has no ready signal and applies no back-pressure. The clock enable is the only stall: on a cycle where it is low, every stage and the flush count hold their values. A producer must expect that any samples it presents while the flush window is open are dropped.

Top module: `flush_pipe`

## Requirements
- R1: Stage k (counting from 0 at the input) applies one operation, chosen by k mod 3. When k mod 3 is 0 it adds k+1. When k mod 3 is 1 it multiplies by 2. When k mod 3 is 2 it multiplies by 3. All results are taken modulo 2^DW. With the defaults (DW=16, DEPTH=5) the output is 12x+20 mod 65536. A sample captured on an enabled edge appears at the output after DEPTH-1 further enabled edges.
- R2: Reset has priority over the enable. A clock edge with `rst` high opens the flush window even when `en` is low, and after that edge `out_valid` and `out_data` are 0.
- R3: While the flush window is open, `out_valid` is 0 and `out_data` is 0.
- R4: While the flush window is open, the first stage receives zero data with valid low. A sample presented during the window never shows up at the output.
- R5: The window closes after DEPTH enabled edges that follow the deassertion of `rst`. Edges with `en` low do not count.
- R6: If `rst` is asserted again while the window is open, the count starts over.
- R7: When the window closes, `out_valid` stays low. The first sample accepted on the next enabled edge appears on the output DEPTH enabled edges later. With `en` held high this is 2·DEPTH edges after reset is released.
- R8: After the first reset, `out_valid` and `out_data` match, cycle for cycle, a model that clears every stage on reset and drops input during the window. `out_data` is 0 whenever `out_valid` is 0.
- R9: While `en` is low and `rst` is low, `out_valid` and `out_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset; opens the flush window |
| en | input | 1 | Clock enable for stages and flush count |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DW | Input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | DW | Output sample, 0 when not valid |

## Verification
The properties assume that the first reset comes before any result matters. They stay quiet until that reset has been seen, because the flush count and the stage contents are undefined until then. The stimulus follows this rule. It drives junk samples with no reset at first, to fill the stages with arbitrary contents. The model comparison starts only at the first reset. After that the stimulus varies the enable, reset and valid freely, including reset while the enable is low and reset again while the window is open.

// File: rtl/flush_pkg.sv
package flush_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_DBL = 2'd1,
    OP_TRI = 2'd2
  } stage_op_e;

  // Operation chosen by the stage index.
  function automatic stage_op_e op_of(input int k);
    case (k % 3)
      0:       return OP_ADD;
      1:       return OP_DBL;
      default: return OP_TRI;
    endcase
  endfunction

endpackage

// File: rtl/flush_seq.sv
module flush_seq #(
  parameter int DEPTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  // Only this state and the gates it drives respond to reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && en) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pipe_stage.sv
module pipe_stage
  import flush_pkg::*;
#(
  parameter int DW  = 16,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          en,
  input  logic          in_vld,
  input  logic [DW-1:0] in_dat,
  output logic          out_vld,
  output logic [DW-1:0] out_dat
);
  localparam stage_op_e     OP     = op_of(IDX);
  localparam logic [DW-1:0] ADDEND = DW'(IDX + 1);

  logic [DW-1:0] res;

  generate
    if (OP == OP_ADD) begin : g_add
      assign res = in_dat + ADDEND;
    end else if (OP == OP_DBL) begin : g_dbl
      assign res = in_dat << 1;
    end else begin : g_tri
      assign res = in_dat + (in_dat << 1);
    end
  endgenerate

  // No reset term: contents are cleared by flushing zeros through.
  always_ff @(posedge clk) begin
    if (en) begin
      out_vld <= in_vld;
      out_dat <= res;
    end
  end
endmodule

// File: rtl/flush_pipe.sv
module flush_pipe #(
  parameter int DW    = 16,
  parameter int DEPTH = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          stage_vld [DEPTH+1];
  logic [DW-1:0] stage_dat [DEPTH+1];

  flush_seq #(.DEPTH(DEPTH)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .busy (busy),
    .cnt  (cnt)
  );

  // Input gate: zeros enter while the window is open.
  assign stage_vld[0] = in_valid & ~busy;
  assign stage_dat[0] = busy ? '0 : in_data;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      pipe_stage #(.DW(DW), .IDX(k)) u_stage (
        .clk     (clk),
        .en      (en),
        .in_vld  (stage_vld[k]),
        .in_dat  (stage_dat[k]),
        .out_vld (stage_vld[k+1]),
        .out_dat (stage_dat[k+1])
      );
    end
  endgenerate

  // Output gate: nothing leaves while the window is open.
  assign out_valid = ~busy & stage_vld[DEPTH];
  assign out_data  = out_valid ? stage_dat[DEPTH] : '0;
endmodule

// File: rtl/flush_pipe_chk.sv
module flush_pipe_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 5,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic          head_vld,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  assert_rst_over_en_R2: assert property (@(posedge clk) disable iff (!armed)
    rst |=> (!out_valid && out_data == '0));

  assert_quiet_in_window_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    busy |-> (!out_valid && out_data == '0));

  assert_zero_feed_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    (busy && en) |=> !head_vld);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    busy |-> (int'(cnt) < DEPTH));

  assert_release_empty_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(busy) |-> !out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    !en |=> ($stable(out_valid) && $stable(out_data)));
endmodule

bind flush_pipe flush_pipe_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .busy      (busy),
  .cnt       (cnt),
  .head_vld  (stage_vld[1]),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_flush_pipe.sv
module tb_flush_pipe;
  localparam int DW = 16;
  localparam int D  = 5;

  // {input, expected output} for the default 12x+20 chain (R1)
  localparam logic [31:0] VEC [8] = '{
    {16'd0,     16'd20},
    {16'd1,     16'd32},
    {16'd2,     16'd44},
    {16'd100,   16'd1220},
    {16'hFFFF,  16'd8},
    {16'h1000,  16'hC014},
    {16'h5555,  16'd16},
    {16'd5000,  16'd60020}
  };

  logic clk = 1'b0;
  logic rst = 1'b0, en = 1'b1, in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  flush_pipe #(.DW(DW), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string phase_req = "R8";

  // Model: every stage cleared on reset, input dropped during window.
  bit            live = 1'b0, mbusy = 1'b0;
  int            mcnt = 0;
  bit            mv [D];
  logic [DW-1:0] md [D];

  function automatic logic [DW-1:0] ref_op(int k, logic [DW-1:0] x);
    case (k % 3)
      0:       return x + DW'(k + 1);
      1:       return DW'(x * 2);
      default: return DW'(x * 3);
    endcase
  endfunction

  function automatic logic [DW-1:0] ref_fn(logic [DW-1:0] x);
    logic [DW-1:0] y = x;
    for (int k = 0; k < D; k++) y = ref_op(k, y);
    return y;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit r = rst, e = en, v = in_valid;
    logic [DW-1:0] d = in_data;
    @(posedge clk);
    if (r) begin
      live = 1'b1; mbusy = 1'b1; mcnt = 0;
      for (int k = 0; k < D; k++) begin mv[k] = 1'b0; md[k] = '0; end
    end else if (e) begin
      for (int k = D - 1; k > 0; k--) begin
        mv[k] = mv[k-1]; md[k] = ref_op(k, md[k-1]);
      end
      mv[0] = mbusy ? 1'b0 : v;
      md[0] = ref_op(0, mbusy ? '0 : d);
      if (mbusy) begin
        mcnt++;
        if (mcnt == D) mbusy = 1'b0;
      end
    end
    #1;
    if (live) begin
      bit ev = !mbusy && mv[D-1];
      check({phase_req, " valid"}, 32'(out_valid), 32'(ev));
      check({phase_req, " data"}, 32'(out_data), ev ? 32'(md[D-1]) : 32'd0);
    end
  endtask

  // Count ticks after reset release until the first valid output.
  task automatic count_to_valid(output int n);
    n = 0;
    for (int i = 1; i <= 3 * D; i++) begin
      in_valid = 1'b1; in_data = DW'(1000 + i);
      tick();
      if (out_valid && n == 0) n = i;
    end
  endtask

  initial begin
    int n;
    logic sv;
    logic [DW-1:0] sd;
    // Junk into the unreset stages, before any reset.
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_data = DW'(i * 777 + 3); tick();
    end
    // R2: reset with enable low still opens the window.
    rst = 1'b1; en = 1'b0; phase_req = "R2"; tick();
    check("R2 out_valid after reset", 32'(out_valid), 0);
    check("R2 out_data after reset", 32'(out_data), 0);
    rst = 1'b0; en = 1'b1; phase_req = "R3";
    // R4/R5/R7: samples during window dropped; first valid at tick 2*D.
    n = 0;
    for (int i = 1; i <= 3 * D; i++) begin
      in_valid = 1'b1; in_data = DW'(1000 + i);
      tick();
      if (i == D) check("R7 no valid at window close", 32'(out_valid), 0);
      if (out_valid && n == 0) begin
        n = i;
        check("R4 first output from first accepted sample", 32'(out_data),
              32'(ref_fn(DW'(1000 + D + 1))));
      end
    end
    check("R5 ticks to first valid", 32'(n), 32'(2 * D));
    // R1: table walk, streamed back to back.
    phase_req = "R1";
    for (int t = 0; t < 8 + D; t++) begin
      in_valid = (t < 8); in_data = (t < 8) ? VEC[t][31:16] : '0;
      tick();
      if (t >= D - 1 && t - (D - 1) < 8) begin
        check("R1 table valid", 32'(out_valid), 1);
        check("R1 table data", 32'(out_data), 32'(VEC[t-(D-1)][15:0]));
      end
    end
    // R9: stall holds outputs mid-stream.
    for (int t = 0; t < D; t++) begin
      in_valid = 1'b1; in_data = DW'(t * 31 + 7); tick();
    end
    sv = out_valid; sd = out_data;
    en = 1'b0; phase_req = "R9";
    for (int t = 0; t < 3; t++) begin
      in_data = DW'(t + 9); tick();
      check("R9 valid held", 32'(out_valid), 32'(sv));
      check("R9 data held", 32'(out_data), 32'(sd));
    end
    en = 1'b1;
    // R5/R8: reset with full pipe, then gappy enable during window.
    rst = 1'b1; tick(); rst = 1'b0; phase_req = "R5";
    for (int t = 0; t < 6 * D; t++) begin
      en = t[0]; in_valid = 1'b1; in_data = DW'(t * 211 + 5); tick();
    end
    en = 1'b1; phase_req = "R8";
    for (int t = 0; t < 2 * D; t++) begin
      in_valid = t[1]; in_data = DW'(t * 97); tick();
    end
    // R6: reset again inside the window restarts the count.
    rst = 1'b1; tick(); rst = 1'b0; phase_req = "R6";
    for (int t = 0; t < 3; t++) begin in_valid = 1'b1; tick(); end
    rst = 1'b1; tick(); rst = 1'b0;
    count_to_valid(n);
    check("R6 ticks to first valid after restart", 32'(n), 32'(2 * D));
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule